// File: doc/BRIEF.md
# Multi-channel PWM timer

A timer core that generates up to four pulse-width-modulated outputs from one shared time base. A prescaler divides the input clock. A main counter advances once per prescaler tick, either upward or downward, between zero and a programmable reload value. The counter's turnaround raises a periodic update event. Every channel compares the count against its own compare value. It raises a compare event on a match, and it drives an output line whose duty cycle is compare / (reload + 1).

Configuration arrives through plain write strobes with data: prescaler, reload, and one compare strobe per channel sharing a data bus. Direction, per-channel enable and per-channel polarity are level inputs. Prescaler, reload, compare and direction are buffered. A running timer adopts new values only at its next update event, so the period in progress is never cut short. While the timer is stopped, written values take effect at once.

Top module: `pwm_timer`

## Requirements
- R1: With `dir_down_i`=0 and prescaler 0, the count steps 0,1,…,reload, then returns to 0. `upd_evt_o` is high for one cycle in each cycle whose count equals reload.
- R2: A prescaler value P makes the counter advance once every P+1 clocks. Starting from the first cycle with `run_i` high, a tick falls in cycles P, 2P+1, 3P+2, …, and the events are high only in tick cycles.
- R3: With `dir_down_i`=1, the count starts at reload and steps down to 0. `upd_evt_o` is high in each tick cycle whose count is 0, and the count then returns to reload.
- R4: `cmp_evt_o[i]` is high in a tick cycle exactly when the count equals the active compare value of channel i.
- R5: An enabled channel is active whenever count < compare, in both directions, so its duty is compare/(reload+1). Active means 1 when `ch_pol_i[i]`=0 and 0 when `ch_pol_i[i]`=1. `pwm_o` is registered and lines up cycle for cycle with `cnt_o`.
- R6: A channel with `ch_en_i[i]`=0 drives its idle level, which is `ch_pol_i[i]`, one cycle later.
- R7: A compare value of 0 gives a constant idle output. A compare value above reload gives a constant active output.
- R8: While running, writes to reload or compare are held and take effect from the cycle after the next update event. The period in progress keeps the old values.
- R9: Reset clears the count, events and outputs. While `run_i` is low, no events occur and, one cycle after stopping, the count sits at its start value: 0 going up, the reload value going down.
- R10: All channels share the reload period while keeping independent compare values and polarities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter run enable |
| dir_down_i | input | 1 | Count direction: 0 up, 1 down |
| psc_we_i | input | 1 | Prescaler write strobe |
| psc_i | input | PSC_W | Prescaler value (divide by value+1) |
| arr_we_i | input | 1 | Reload write strobe |
| arr_i | input | CNT_W | Reload value |
| cmp_we_i | input | N_CH | Per-channel compare write strobes |
| cmp_i | input | CNT_W | Compare value, shared by all channels |
| ch_en_i | input | N_CH | Per-channel output enable |
| ch_pol_i | input | N_CH | Per-channel polarity: 1 active low |
| cnt_o | output | CNT_W | Current count |
| upd_evt_o | output | 1 | Periodic update event |
| cmp_evt_o | output | N_CH | Per-channel compare events |
| pwm_o | output | N_CH | PWM outputs |

## Verification
The events are decoded from registered state and from `run_i`, so they are due in the same cycle as the count value that causes them. The count and `pwm_o` change one edge after each tick. A write reaches its shadow register at the following edge and becomes active at the edge that ends the next update-event cycle. The bench drives inputs one time unit after a rising edge and samples at the falling edge. It derives the count of cycle n arithmetically, as floor(n/(P+1)) taken modulo reload+1, and it checks every output in every cycle across a sweep of prescaler, reload, direction, compare, enable and polarity settings.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_sh_q, psc_act_q, psc_cnt_q;

  assign tick_o = run_i && (psc_cnt_q == psc_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_sh_q  <= '0;
      psc_act_q <= '0;
      psc_cnt_q <= '0;
    end else begin
      if (psc_we_i) psc_sh_q <= psc_i;
      if (load_i)   psc_act_q <= psc_sh_q;
      if (!run_i || tick_o) psc_cnt_q <= '0;
      else                  psc_cnt_q <= psc_cnt_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || psc_act_q == '0)); // R2
  AST_PSC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (psc_cnt_q <= psc_act_q)); // R2
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             dir_down_i,
  input  logic             tick_i,
  input  logic             arr_we_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             upd_evt_o,
  output logic             load_o
);
  cnt_dir_e         dir_act_q;
  logic [CNT_W-1:0] arr_sh_q, arr_act_q, cnt_q, cnt_nxt, start_val;
  logic             at_limit;

  assign at_limit  = (dir_act_q == CNT_DOWN) ? (cnt_q == '0) : (cnt_q == arr_act_q);
  assign upd_evt_o = tick_i && at_limit;
  assign load_o    = !run_i || upd_evt_o;
  assign start_val = dir_down_i ? arr_sh_q : '0;

  always_comb begin
    cnt_nxt = cnt_q;
    if (!run_i) begin
      cnt_nxt = start_val;
    end else if (tick_i) begin
      if (at_limit)                    cnt_nxt = start_val;
      else if (dir_act_q == CNT_DOWN)  cnt_nxt = cnt_q - 1'b1;
      else                             cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_sh_q  <= '1;
      arr_act_q <= '1;
      cnt_q     <= '0;
      dir_act_q <= CNT_UP;
    end else begin
      cnt_q <= cnt_nxt;
      if (arr_we_i) arr_sh_q <= arr_i;
      if (load_o) begin
        arr_act_q <= arr_sh_q;
        dir_act_q <= cnt_dir_e'(dir_down_i);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_nxt;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= arr_act_q); // R1
  AST_ARR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !upd_evt_o) |=> $stable(arr_act_q)); // R8
  AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_evt_o && dir_down_i) |=> (cnt_q == arr_act_q)); // R3
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             en_i,
  input  logic             pol_i,
  output logic             cmp_evt_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_sh_q, cmp_act_q, cmp_nxt;
  logic             pwm_q;

  assign cmp_nxt   = load_i ? cmp_sh_q : cmp_act_q;
  assign cmp_evt_o = tick_i && (cnt_i == cmp_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_sh_q  <= '0;
      cmp_act_q <= '0;
      pwm_q     <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_sh_q <= cmp_i;
      cmp_act_q <= cmp_nxt;
      // active while the next count sits below the next compare value
      pwm_q <= pol_i ^ (en_i && (cnt_nxt_i < cmp_nxt));
    end
  end

  assign pwm_o = pwm_q;

  AST_OFF_IS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pwm_o == $past(pol_i))); // R6
  AST_ZERO_CMP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_nxt == '0) |=> (pwm_o == $past(pol_i))); // R7
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  parameter int unsigned N_CH  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             dir_down_i,
  input  logic             psc_we_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             arr_we_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [N_CH-1:0]  cmp_we_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [N_CH-1:0]  ch_en_i,
  input  logic [N_CH-1:0]  ch_pol_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_evt_o,
  output logic [N_CH-1:0]  cmp_evt_o,
  output logic [N_CH-1:0]  pwm_o
);
  logic             tick, load, upd_evt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .load_i   (load),
    .psc_we_i (psc_we_i),
    .psc_i    (psc_i),
    .tick_o   (tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .dir_down_i (dir_down_i),
    .tick_i     (tick),
    .arr_we_i   (arr_we_i),
    .arr_i      (arr_i),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt),
    .upd_evt_o  (upd_evt),
    .load_o     (load)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .tick_i    (tick),
      .cmp_we_i  (cmp_we_i[g]),
      .cmp_i     (cmp_i),
      .cnt_i     (cnt),
      .cnt_nxt_i (cnt_nxt),
      .en_i      (ch_en_i[g]),
      .pol_i     (ch_pol_i[g]),
      .cmp_evt_o (cmp_evt_o[g]),
      .pwm_o     (pwm_o[g])
    );
  end

  assign cnt_o     = cnt;
  assign upd_evt_o = upd_evt;

  AST_EVT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!upd_evt_o && cmp_evt_o == '0)); // R9
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;
  localparam int N_CH  = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             run_i = 1'b0;
  logic             dir_down_i = 1'b0;
  logic             psc_we_i = 1'b0;
  logic [PSC_W-1:0] psc_i = '0;
  logic             arr_we_i = 1'b0;
  logic [CNT_W-1:0] arr_i = '0;
  logic [N_CH-1:0]  cmp_we_i = '0;
  logic [CNT_W-1:0] cmp_i = '0;
  logic [N_CH-1:0]  ch_en_i = '0;
  logic [N_CH-1:0]  ch_pol_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic             upd_evt_o;
  logic [N_CH-1:0]  cmp_evt_o;
  logic [N_CH-1:0]  pwm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cfg_cmp [N_CH];
  int exp_cmp [N_CH];
  logic [N_CH-1:0] en_v, pol_v;

  pwm_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .N_CH(N_CH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .dir_down_i(dir_down_i),
    .psc_we_i(psc_we_i), .psc_i(psc_i), .arr_we_i(arr_we_i), .arr_i(arr_i),
    .cmp_we_i(cmp_we_i), .cmp_i(cmp_i), .ch_en_i(ch_en_i), .ch_pol_i(ch_pol_i),
    .cnt_o(cnt_o), .upd_evt_o(upd_evt_o), .cmp_evt_o(cmp_evt_o), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // all outputs of one cycle against arithmetic expectations
  task automatic chk_cycle(string ph, int ce, int te, int a, int dn, int p);
    string rc, t;
    rc = (p > 0) ? "R2" : (dn != 0 ? "R3" : "R1");
    chk(rc, {ph, " count"}, int'(cnt_o), ce);
    chk(rc, {ph, " update event"}, int'(upd_evt_o),
        int'(te != 0 && ce == (dn != 0 ? 0 : a)));
    for (int i = 0; i < N_CH; i++) begin
      chk("R4", {ph, " compare event"}, int'(cmp_evt_o[i]),
          int'(te != 0 && ce == exp_cmp[i]));
      if (!ch_en_i[i])                          t = "R6";
      else if (exp_cmp[i] == 0 || exp_cmp[i] > a) t = "R7";
      else if (i == 0)                          t = "R5";
      else                                      t = "R10";
      chk(t, {ph, " pwm"}, int'(pwm_o[i]),
          int'(ch_pol_i[i] ^ (ch_en_i[i] && ce < exp_cmp[i])));
    end
  endtask

  task automatic apply_cfg(int p, int a, int dn);
    run_i = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      cmp_we_i = N_CH'(1) << i;
      cmp_i    = CNT_W'(cfg_cmp[i]);
      step();
    end
    cmp_we_i   = '0;
    psc_we_i   = 1'b1;
    psc_i      = PSC_W'(p);
    arr_we_i   = 1'b1;
    arr_i      = CNT_W'(a);
    dir_down_i = (dn != 0);
    ch_en_i    = en_v;
    ch_pol_i   = pol_v;
    step();
    psc_we_i = 1'b0;
    arr_we_i = 1'b0;
    step();
    for (int i = 0; i < N_CH; i++) exp_cmp[i] = cfg_cmp[i];
    @(negedge clk_i);
    chk_cycle("R9 stopped", (dn != 0) ? a : 0, 0, a, dn, p);
    step();
  endtask

  task automatic run_span(int p, int a, int dn, int cycles);
    int k, ce, te;
    run_i = 1'b1;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk_i);
      k  = n / (p + 1);
      ce = (dn != 0) ? a - (k % (a + 1)) : k % (a + 1);
      te = int'((n % (p + 1)) == p);
      chk_cycle("sweep", ce, te, a, dn, p);
      step();
    end
    run_i = 1'b0;
  endtask

  initial begin
    int vals [5];
    int idx, a;
    @(negedge clk_i);
    chk("R9", "reset count", int'(cnt_o), 0);
    chk("R9", "reset update event", int'(upd_evt_o), 0);
    chk("R9", "reset compare events", int'(cmp_evt_o), 0);
    chk("R9", "reset pwm", int'(pwm_o), 0);
    rst_ni = 1'b1;
    step();

    idx = 0;
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 3; p++) begin
        for (int ai = 0; ai < 3; ai++) begin
          a = (ai == 0) ? 2 : (ai == 1) ? 4 : 5;
          vals[0] = 1; vals[1] = a; vals[2] = 0; vals[3] = a + 3; vals[4] = (a + 1) / 2;
          for (int i = 0; i < N_CH; i++) cfg_cmp[i] = vals[(i + idx) % 5];
          en_v  = N_CH'(4'hF & ~(5'd1 << (idx % 5)));
          pol_v = N_CH'(idx * 5);
          apply_cfg(p, a, d);
          run_span(p, a, d, 2 * (a + 1) * (p + 1) + 3);
          idx++;
        end
      end
    end

    // R8: reload and compare written mid-period, applied after the wrap
    cfg_cmp[0] = 2; cfg_cmp[1] = 1; cfg_cmp[2] = 4; cfg_cmp[3] = 0;
    en_v  = 4'hF;
    pol_v = 4'b0010;
    apply_cfg(0, 4, 0);
    run_i = 1'b1;
    for (int n = 0; n < 22; n++) begin
      if (n == 1) begin
        arr_we_i = 1'b1; arr_i = 16'd6;
        cmp_we_i = 4'b0001; cmp_i = 16'd5;
      end
      if (n == 2) begin
        arr_we_i = 1'b0;
        cmp_we_i = '0;
      end
      @(negedge clk_i);
      if (n < 5) begin
        exp_cmp[0] = 2;
        chk_cycle("R8 old period", n, 1, 4, 0, 0);
      end else begin
        exp_cmp[0] = 5;
        chk_cycle("R8 new period", (n - 5) % 7, 1, 6, 0, 0);
      end
      step();
    end

    // R9: stop mid-period
    run_i = 1'b0;
    @(negedge clk_i);
    chk("R9", "stop cycle update event", int'(upd_evt_o), 0);
    chk("R9", "stop cycle compare events", int'(cmp_evt_o), 0);
    step();
    for (int n = 0; n < 3; n++) begin
      @(negedge clk_i);
      chk("R9", "stopped count", int'(cnt_o), 0);
      chk("R9", "stopped update event", int'(upd_evt_o), 0);
      chk("R9", "stopped compare events", int'(cmp_evt_o), 0);
      step();
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule